// File: doc/BRIEF.md
# Time-Slotted Closed-Page DRAM Scheduler

This block turns one memory request per schedule slot into a fixed command sequence for a simple SDRAM command interface. An external arbiter marks the start of each slot with a one-cycle strobe and says whether the slot is a data slot or the refresh slot of the schedule. In a data slot, the request present with the strobe is issued as a row activate and then a column read or write with auto-precharge. The row is therefore closed again within the same slot, and no slot inherits an open row from the slot before it. Read data comes back with a valid pulse at a constant offset from the slot strobe.

Each partition is pinned to a private bank, so the bank state one partition sees is never disturbed by another partition. In the refresh slot only a refresh command is sent. A request offered at the start of that slot is not issued. Instead it is flagged for retry, and the requester keeps it for a later data slot. DRAM timing values (activate-to-column, CAS latency, precharge, row active time, refresh time) are parameters. Elaboration checks that the slot length covers the longest access, the read return and the refresh, and that the partitions fit in the banks.

Top module: `slotdram_sched`

## Requirements
- R1: While reset is asserted and after it is released with no slot strobe, dram_cmd is NOP (0), rd_valid is 0 and req_retry is 0.
- R2: When slot_start is high in a data slot with req_valid high, the cycle after it carries ACT (1), with dram_addr equal to req_row zero-extended.
- R3: Exactly TRCD cycles after the ACT, the column command RD (2) or WR (3) with auto-precharge is issued. dram_addr carries req_col zero-extended, and dram_wdata carries the write data in the WR cycle and 0 otherwise. Every other cycle of the slot is NOP with bank, address and write data at 0.
- R4: For a read, rd_valid pulses for one cycle exactly TRCD+TCL+2 cycles after the slot_start cycle. rd_data then equals the value on dram_rdata TCL cycles after the RD command.
- R5: dram_bank on both commands of an access equals req_part plus BANK_OFFSET. Elaboration rejects NUM_PARTS+BANK_OFFSET greater than NUM_BANKS.
- R6: In a refresh slot (slot_is_refresh high with slot_start), the cycle after the strobe carries REF (4) and the rest of the slot is NOP.
- R7: A request valid at the start of a refresh slot is not issued. req_retry is high for exactly the cycle that carries REF.
- R8: Requests are sampled only in the slot_start cycle. req_valid at any other cycle, or a data slot with req_valid low, produces no command.
- R9: The cycle positions of ACT, the column command and rd_valid are identical whatever access preceded them, including a different row of the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | One-cycle strobe at the start of a slot |
| slot_is_refresh | input | 1 | With slot_start: this slot is the refresh slot |
| req_valid | input | 1 | A request is offered |
| req_part | input | PART_W | Partition of the request |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_retry | output | 1 | Request refused in the refresh slot, offer it again later |
| dram_cmd | output | 3 | Command: 0 NOP, 1 ACT, 2 RD+AP, 3 WR+AP, 4 REF |
| dram_bank | output | BANK_W | Bank of ACT/RD/WR |
| dram_addr | output | ADDR_W | Row on ACT, column on RD/WR |
| dram_wdata | output | DATA_W | Write data in the WR cycle |
| dram_rdata | input | DATA_W | Read data from the device |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data returned |

## Verification
The arrival of a valid request and the refresh slot can coincide on the same strobe cycle. This is the case where the retry flag and the refresh command must appear together, and no activate may follow. The bench provokes it by raising req_valid together with slot_is_refresh. It judges the outcome by a cycle-by-cycle comparison of the command bus over the whole slot. It then offers the same request in the following data slot and checks that it completes with the normal timing.

// File: rtl/slotdram_pkg.sv
package slotdram_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_REF = 3'd4
   } dram_cmd_e;
endpackage

// File: rtl/slotdram_bankmap.sv
module slotdram_bankmap #(
   parameter int PART_W      = 2,
   parameter int BANK_W      = 2,
   parameter int BANK_OFFSET = 0
) (
   input  logic [PART_W-1:0] part,
   output logic [BANK_W-1:0] bank
);
   generate
      if (BANK_OFFSET == 0) begin : g_direct
         assign bank = BANK_W'(part);
      end else begin : g_offset
         assign bank = BANK_W'(part) + BANK_W'(BANK_OFFSET);
      end
   endgenerate
endmodule

// File: rtl/slotdram_seq.sv
module slotdram_seq
   import slotdram_pkg::*;
#(
   parameter int ROW_W  = 12,
   parameter int COL_W  = 8,
   parameter int DATA_W = 16,
   parameter int BANK_W = 2,
   parameter int ADDR_W = 12,
   parameter int TRCD   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_start,
   input  logic              slot_is_refresh,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BANK_W-1:0] bank_in,
   output dram_cmd_e         cmd,
   output logic [BANK_W-1:0] bank,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic              retry
);
   localparam int PH_W = (TRCD < 2) ? 1 : $clog2(TRCD);

   logic              busy;
   logic [PH_W-1:0]   ph;
   logic              op_wr;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd     <= CMD_NOP;
         bank    <= '0;
         addr    <= '0;
         wdata   <= '0;
         retry   <= 1'b0;
         busy    <= 1'b0;
         ph      <= '0;
         op_wr   <= 1'b0;
         bank_q  <= '0;
         col_q   <= '0;
         wdata_q <= '0;
      end else begin
         cmd   <= CMD_NOP;
         bank  <= '0;
         addr  <= '0;
         wdata <= '0;
         retry <= 1'b0;
         if (slot_start) begin
            busy <= 1'b0;
            if (slot_is_refresh) begin
               cmd   <= CMD_REF;
               retry <= req_valid;
            end else if (req_valid) begin
               cmd     <= CMD_ACT;
               bank    <= bank_in;
               addr    <= ADDR_W'(req_row);
               busy    <= 1'b1;
               ph      <= '0;
               op_wr   <= req_write;
               bank_q  <= bank_in;
               col_q   <= req_col;
               wdata_q <= req_wdata;
            end
         end else if (busy) begin
            ph <= ph + 1'b1;
            if (ph == PH_W'(TRCD - 1)) begin
               cmd   <= op_wr ? CMD_WR : CMD_RD;
               bank  <= bank_q;
               addr  <= ADDR_W'(col_q);
               wdata <= op_wr ? wdata_q : '0;
               busy  <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/slotdram_rdret.sv
module slotdram_rdret #(
   parameter int DATA_W = 16,
   parameter int TCL    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issued,
   input  logic [DATA_W-1:0] dram_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   logic [TCL-1:0] track;

   generate
      if (TCL == 1) begin : g_short
         always_ff @(posedge clk) begin
            if (!rst_n) track <= '0;
            else        track <= rd_issued;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) track <= '0;
            else        track <= {track[TCL-2:0], rd_issued};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= track[TCL-1];
         if (track[TCL-1]) rd_data <= dram_rdata;
      end
   end
endmodule

// File: rtl/slotdram_sched.sv
module slotdram_sched
   import slotdram_pkg::*;
#(
   parameter int NUM_PARTS   = 4,
   parameter int NUM_BANKS   = 4,
   parameter int BANK_OFFSET = 0,
   parameter int ROW_W       = 12,
   parameter int COL_W       = 8,
   parameter int DATA_W      = 16,
   parameter int TRCD        = 3,
   parameter int TCL         = 3,
   parameter int TRP         = 3,
   parameter int TRAS        = 7,
   parameter int TRFC        = 10,
   parameter int SLOT_LEN    = 16,
   localparam int PART_W     = (NUM_PARTS < 2) ? 1 : $clog2(NUM_PARTS),
   localparam int BANK_W     = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS),
   localparam int ADDR_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_start,
   input  logic              slot_is_refresh,
   input  logic              req_valid,
   input  logic [PART_W-1:0] req_part,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_retry,
   output logic [2:0]        dram_cmd,
   output logic [BANK_W-1:0] dram_bank,
   output logic [ADDR_W-1:0] dram_addr,
   output logic [DATA_W-1:0] dram_wdata,
   input  logic [DATA_W-1:0] dram_rdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PRE_AT   = (TRAS > TRCD + 1) ? TRAS : TRCD + 1;
   localparam int ACC_LEN  = PRE_AT + TRP;
   localparam int RET_LEN  = TRCD + TCL + 2;
   localparam int REF_LEN  = TRFC + 1;
   localparam int MAX_AR   = (ACC_LEN > RET_LEN) ? ACC_LEN : RET_LEN;
   localparam int SLOT_MIN = (MAX_AR > REF_LEN) ? MAX_AR : REF_LEN;

   generate
      if (TRCD < 1 || TCL < 1) begin : g_bad_timing
         $error("slotdram_sched: TRCD and TCL must be at least 1");
      end
      if (NUM_PARTS + BANK_OFFSET > NUM_BANKS) begin : g_bad_map
         $error("slotdram_sched: partitions do not fit in private banks");
      end
      if (SLOT_LEN < SLOT_MIN) begin : g_bad_slot
         $error("slotdram_sched: SLOT_LEN shorter than access or refresh");
      end
   endgenerate

   logic [BANK_W-1:0] mapped_bank;
   dram_cmd_e         cmd;

   slotdram_bankmap #(
      .PART_W(PART_W), .BANK_W(BANK_W), .BANK_OFFSET(BANK_OFFSET)
   ) u_map (
      .part(req_part), .bank(mapped_bank)
   );

   slotdram_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
      .BANK_W(BANK_W), .ADDR_W(ADDR_W), .TRCD(TRCD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .slot_start(slot_start), .slot_is_refresh(slot_is_refresh),
      .req_valid(req_valid), .req_write(req_write),
      .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
      .bank_in(mapped_bank),
      .cmd(cmd), .bank(dram_bank), .addr(dram_addr),
      .wdata(dram_wdata), .retry(req_retry)
   );

   slotdram_rdret #(.DATA_W(DATA_W), .TCL(TCL)) u_ret (
      .clk(clk), .rst_n(rst_n),
      .rd_issued(cmd == CMD_RD),
      .dram_rdata(dram_rdata),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   assign dram_cmd = cmd;
endmodule

// File: rtl/slotdram_sched_chk.sv
module slotdram_sched_chk #(
   parameter int TRCD      = 3,
   parameter int TCL       = 3,
   parameter int SLOT_LEN  = 16,
   parameter int PART_W    = 2,
   parameter int BANK_W    = 2,
   parameter int BANK_OFFSET = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              slot_start,
   input logic              slot_is_refresh,
   input logic              req_valid,
   input logic [PART_W-1:0] req_part,
   input logic              req_retry,
   input logic [2:0]        dram_cmd,
   input logic [BANK_W-1:0] dram_bank,
   input logic              rd_valid
);
   logic [15:0] gap, act_age, rd_age;
   logic [1:0]  acts;
   logic        seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap <= '0; act_age <= '0; rd_age <= '0; acts <= '0; seen <= 1'b0;
      end else begin
         if (slot_start) begin
            gap <= 16'd1; seen <= 1'b1; acts <= '0;
         end else if (gap != 16'hffff) gap <= gap + 16'd1;
         if (dram_cmd == 3'd1) begin
            act_age <= 16'd1;
            if (!slot_start && acts != 2'd3) acts <= acts + 2'd1;
         end else if (act_age != 16'hffff) act_age <= act_age + 16'd1;
         if (dram_cmd == 3'd2) rd_age <= 16'd1;
         else if (rd_age != 16'hffff) rd_age <= rd_age + 16'd1;
      end
   end

   AST_SLOT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && seen) |-> (gap >= 16'(SLOT_LEN))); // R9
   AST_ACT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 3'd1) |-> $past(slot_start && !slot_is_refresh && req_valid)); // R2
   AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 3'd1) |-> (acts == 2'd0)); // R3
   AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 3'd2 || dram_cmd == 3'd3) |-> (act_age == 16'(TRCD))); // R3
   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_age == 16'(TCL + 1))); // R4
   AST_PRIVATE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 3'd1) |-> (dram_bank == BANK_W'($past(req_part)) + BANK_W'(BANK_OFFSET))); // R5
   AST_REF_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd == 3'd4) |-> $past(slot_start && slot_is_refresh)); // R6
   AST_RETRY_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
      req_retry |-> (dram_cmd == 3'd4)); // R7
   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(!rst_n) |-> (dram_cmd == 3'd0 && !rd_valid && !req_retry)); // R1
endmodule

bind slotdram_sched slotdram_sched_chk #(
   .TRCD(TRCD), .TCL(TCL), .SLOT_LEN(SLOT_LEN),
   .PART_W(PART_W), .BANK_W(BANK_W), .BANK_OFFSET(BANK_OFFSET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
   .slot_is_refresh(slot_is_refresh), .req_valid(req_valid),
   .req_part(req_part), .req_retry(req_retry), .dram_cmd(dram_cmd),
   .dram_bank(dram_bank), .rd_valid(rd_valid)
);

// File: tb/slotdram_sched_test.sv
module slotdram_sched_test;
   localparam int NP = 4, NB = 4, RW = 12, CW = 8, DW = 16;
   localparam int TRCD = 3, TCL = 3, SLOT = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slot_start = 0, slot_is_refresh = 0, req_valid = 0, req_write = 0;
   logic [1:0]    req_part = '0;
   logic [RW-1:0] req_row = '0;
   logic [CW-1:0] req_col = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_retry, rd_valid;
   logic [2:0]    dram_cmd;
   logic [1:0]    dram_bank;
   logic [RW-1:0] dram_addr;
   logic [DW-1:0] dram_wdata, dram_rdata, rd_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   slotdram_sched #(
      .NUM_PARTS(NP), .NUM_BANKS(NB), .BANK_OFFSET(0), .ROW_W(RW), .COL_W(CW),
      .DATA_W(DW), .TRCD(TRCD), .TCL(TCL), .TRP(3), .TRAS(7), .TRFC(10),
      .SLOT_LEN(SLOT)
   ) uut (
      .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
      .slot_is_refresh(slot_is_refresh), .req_valid(req_valid),
      .req_part(req_part), .req_row(req_row), .req_col(req_col),
      .req_write(req_write), .req_wdata(req_wdata), .req_retry(req_retry),
      .dram_cmd(dram_cmd), .dram_bank(dram_bank), .dram_addr(dram_addr),
      .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // simple device model: data keyed by bank and column, returned TCL cycles after RD
   logic [DW-1:0] mem [NB][1<<CW];
   logic [DW-1:0] rpipe [TCL];
   initial begin
      for (int b = 0; b < NB; b++)
         for (int c = 0; c < (1<<CW); c++) mem[b][c] = 16'hdead;
      for (int i = 0; i < TCL; i++) rpipe[i] = 16'hbeef;
   end
   always @(posedge clk) begin
      if (dram_cmd == 3'd3) mem[dram_bank][dram_addr[CW-1:0]] <= dram_wdata;
      rpipe[0] <= (dram_cmd == 3'd2) ? mem[dram_bank][dram_addr[CW-1:0]] : 16'hbeef;
      for (int i = 1; i < TCL; i++) rpipe[i] <= rpipe[i-1];
   end
   assign dram_rdata = rpipe[TCL-1];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // one slot: strobe cycle, then SLOT-1 cycles checked one by one
   task automatic run_slot(input bit refr, input bit vld, input logic [1:0] part,
                           input logic [RW-1:0] row, input logic [CW-1:0] col,
                           input bit wr, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rexp, input bit hold, input string tag);
      @(negedge clk);
      slot_start = 1; slot_is_refresh = refr; req_valid = vld;
      req_part = part; req_row = row; req_col = col; req_write = wr; req_wdata = wd;
      @(negedge clk);
      slot_start = 0; slot_is_refresh = 0; req_valid = hold;
      for (int c = 0; c < SLOT - 1; c++) begin
         logic [2:0]    ecmd;
         logic [1:0]    ebank;
         logic [RW-1:0] eaddr;
         logic [DW-1:0] ewd;
         bit            eret, erv;
         ecmd = 3'd0; ebank = '0; eaddr = '0; ewd = '0; eret = 0; erv = 0;
         if (c == 0 && refr) begin ecmd = 3'd4; eret = vld; end
         else if (c == 0 && vld) begin ecmd = 3'd1; ebank = part; eaddr = row; end
         else if (c == TRCD && !refr && vld) begin
            ecmd = wr ? 3'd3 : 3'd2; ebank = part; eaddr = RW'(col);
            ewd = wr ? wd : '0;
         end
         if (c == TRCD + TCL + 1 && !refr && vld && !wr) erv = 1;
         check(dram_cmd == ecmd, {tag, "/R2 R3 R6"}, $sformatf("cmd c%0d", c), dram_cmd, ecmd);
         check(dram_bank == ebank, {tag, "/R5"}, $sformatf("bank c%0d", c), dram_bank, ebank);
         check(dram_addr == eaddr, {tag, "/R3"}, $sformatf("addr c%0d", c), dram_addr, eaddr);
         check(dram_wdata == ewd, {tag, "/R3"}, $sformatf("wdata c%0d", c), dram_wdata, ewd);
         check(req_retry == eret, {tag, "/R7"}, $sformatf("retry c%0d", c), req_retry, eret);
         check(rd_valid == erv, {tag, "/R4"}, $sformatf("rd_valid c%0d", c), rd_valid, erv);
         if (erv) check(rd_data == rexp, {tag, "/R4"}, "rd_data", rd_data, rexp);
         if (c < SLOT - 2) @(negedge clk);
      end
      req_valid = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(dram_cmd == 3'd0, "R1", "cmd in reset", dram_cmd, 0);
      check(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
      check(req_retry == 1'b0, "R1", "retry in reset", req_retry, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);
      check(dram_cmd == 3'd0, "R1", "cmd after reset", dram_cmd, 0);
      check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
   endtask

   task automatic t_write_read();
      run_slot(0, 1, 2'd0, 12'h123, 8'h45, 1, 16'ha5a5, '0, 0, "R2");
      run_slot(0, 1, 2'd0, 12'h123, 8'h45, 0, '0, 16'ha5a5, 0, "R4");
   endtask

   task automatic t_all_parts();
      for (int p = 0; p < NP; p++)
         run_slot(0, 1, 2'(p), 12'(p * 37 + 1), 8'h10, 1, 16'(16'h1100 + p), '0, 0, "R5");
      for (int p = NP - 1; p >= 0; p--)
         run_slot(0, 1, 2'(p), 12'(p * 37 + 1), 8'h10, 0, '0, 16'(16'h1100 + p), 0, "R5");
   endtask

   task automatic t_refresh();
      run_slot(1, 0, 2'd0, '0, '0, 0, '0, '0, 0, "R6");
   endtask

   task automatic t_refresh_collide();
      run_slot(1, 1, 2'd3, 12'h0ff, 8'h22, 1, 16'h5a5a, '0, 0, "R7");
      run_slot(0, 1, 2'd3, 12'h0ff, 8'h22, 1, 16'h5a5a, '0, 0, "R7");
      run_slot(0, 1, 2'd3, 12'h0ff, 8'h22, 0, '0, 16'h5a5a, 0, "R7");
   endtask

   task automatic t_ignore();
      run_slot(0, 0, 2'd1, 12'h777, 8'h33, 0, '0, '0, 1, "R8");
      run_slot(0, 0, 2'd2, 12'h001, 8'h01, 1, 16'hffff, '0, 0, "R8");
      // the write in an empty slot must not have reached bank 2 column 1
      run_slot(0, 1, 2'd2, 12'h001, 8'h01, 0, '0, 16'hdead, 0, "R8");
   endtask

   task automatic t_history();
      run_slot(0, 1, 2'd2, 12'h005, 8'h07, 1, 16'h0c0c, '0, 0, "R9");
      run_slot(0, 1, 2'd2, 12'h009, 8'h07, 0, '0, 16'h0c0c, 0, "R9");
      run_slot(0, 1, 2'd2, 12'h005, 8'h07, 0, '0, 16'h0c0c, 0, "R9");
      run_slot(1, 0, 2'd0, '0, '0, 0, '0, '0, 0, "R9");
      run_slot(0, 1, 2'd2, 12'hfff, 8'h07, 0, '0, 16'h0c0c, 0, "R9");
   endtask

   initial begin
      t_reset();
      t_write_read();
      t_all_parts();
      t_refresh();
      t_refresh_collide();
      t_ignore();
      t_history();
      repeat (4) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule